// File: doc/BRIEF.md
# Bus Request Burst Splitter

This block sits between a processor's memory request port and an AHB-Lite master port. A request gives a start address, a word count and a direction. The block turns it into a run of bus packets. Each packet is one word, a four-beat incrementing burst or an eight-beat incrementing burst. Packet sizes are chosen greedily: the largest size that still fits in the remaining count is used.

The bus side is pipelined and uses registered outputs. The address phase of one beat overlaps the data phase of the beat before it. A low HREADY freezes both phases. Write words enter through a valid/ready pair and are taken one per issued beat. Read words leave through a valid strobe, in address order. When the last data phase ends, a one-cycle done pulse is raised. An error response stops the request early, and done is then raised together with an error flag.

Top module: `burst_splitter`

## Requirements
- R1: During and right after reset, HTRANS is IDLE, done, error and rd_valid are low, and req_ready is high.
- R2: Packets are chosen greedily: eight beats while at least 8 words remain, then four beats while at least 4 remain, then single beats. HBURST is 3'b101 for eight beats, 3'b011 for four beats and 3'b000 for one beat, and HSIZE is always 3'b010 (word).
- R3: HTRANS is encoded IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10, SEQ=2'b11. The first beat of a packet is NONSEQ and every later beat is SEQ. Each beat's HADDR is the previous beat's address plus 4, starting at the request address.
- R4: While HREADY is low, the pending address phase (HTRANS, HADDR, HBURST) holds unchanged and the current data phase is extended.
- R5: On a write, one word is taken through wr_valid/wr_ready for each issued beat and is driven on HWDATA during that beat's data phase. If no word is offered, the block drives BUSY inside a packet, or IDLE between packets, until a word arrives.
- R6: On a read, each beat's HRDATA is returned on rd_data with rd_valid high, one cycle after its data phase completes, in address order.
- R7: done pulses for one cycle after the final data phase completes. req_ready is high only while the block is idle, and HTRANS is IDLE whenever req_ready is high.
- R8: A request with a word count of zero raises done in the cycle after it is accepted and causes no NONSEQ or SEQ transfer.
- R9: An ERROR response (HRESP high) in a data phase cancels every remaining beat. No further NONSEQ or SEQ transfer is issued, no read word is returned for the failing beat, and done is raised with error high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when both high |
| req_addr | input | AW | Start byte address (word aligned) |
| req_words | input | CW | Number of words to transfer |
| req_write | input | 1 | 1 for write, 0 for read |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken this cycle |
| wr_data | input | DW | Write word |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DW | Read word |
| done | output | 1 | Request finished (one-cycle pulse) |
| error | output | 1 | Request ended by an error response, valid with done |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Bus transfer type |
| hburst | output | 3 | Bus burst type |
| hsize | output | 3 | Bus transfer size |
| hwrite | output | 1 | Bus direction |
| hwdata | output | DW | Bus write data |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | Bus error response |
| hrdata | input | DW | Bus read data |

## Verification
The bench keeps a 32-bit address and data path and narrows the count to CW=6. This makes a request of the largest count (63 words) cheap to run, and that request exercises all three packet sizes in one go. The 32-bit address allows requests to start at arbitrary word-aligned locations. Random HREADY stalls, gaps in the write-word stream and an error injected mid-burst are handled by the same slave model, so the hold rules, BUSY insertion and abort are all reached.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;

  localparam logic [2:0] HB_SINGLE = 3'b000;
  localparam logic [2:0] HB_INCR4  = 3'b011;
  localparam logic [2:0] HB_INCR8  = 3'b101;
  localparam logic [2:0] HS_WORD   = 3'b010;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_ABORT
  } split_st_e;
endpackage

// File: rtl/bsplit_pkt_sel.sv
// Greedy packet size choice from the number of words still to issue.
module bsplit_pkt_sel #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] remain,
  output logic [2:0]    burst,
  output logic [2:0]    beats_m1
);
  import bsplit_pkg::*;

  localparam logic [CW-1:0] LONG_N  = CW'(8);
  localparam logic [CW-1:0] SHORT_N = CW'(4);

  always_comb begin
    if (remain >= LONG_N) begin
      burst    = HB_INCR8;
      beats_m1 = 3'd7;
    end else if (remain >= SHORT_N) begin
      burst    = HB_INCR4;
      beats_m1 = 3'd3;
    end else begin
      burst    = HB_SINGLE;
      beats_m1 = 3'd0;
    end
  end
endmodule

// File: rtl/bsplit_wbuf.sv
// Stages a write word from address issue until its data phase.
module bsplit_wbuf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          take,
  input  logic [DW-1:0] wdata_in,
  output logic [DW-1:0] hwdata
);
  logic [DW-1:0] stage_q;
  logic [DW-1:0] bus_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      bus_q   <= '0;
    end else begin
      if (adv)  bus_q   <= stage_q;
      if (take) stage_q <= wdata_in;
    end
  end

  assign hwdata = bus_q;
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_words,
  input  logic          req_write,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic [2:0]    hburst,
  output logic [2:0]    hsize,
  output logic          hwrite,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic          hresp,
  input  logic [DW-1:0] hrdata
);
  import bsplit_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [CW-1:0] ONE  = CW'(1);

  split_st_e     st_q;
  htrans_e       htrans_q;
  logic [AW-1:0] haddr_q, nxt_addr_q;
  logic [2:0]    hburst_q;
  logic          hwrite_q;
  logic [CW-1:0] remain_q;
  logic [2:0]    pkt_left_q;
  logic          dp_active_q, dp_write_q;
  logic          done_q, err_q;
  logic          rd_valid_q;
  logic [DW-1:0] rd_data_q;

  logic [2:0] sel_burst, sel_m1;
  logic       adv, can_issue, issue, err_start;

  bsplit_pkt_sel #(.CW(CW)) u_sel (
    .remain   (remain_q),
    .burst    (sel_burst),
    .beats_m1 (sel_m1)
  );

  assign adv       = hready;
  assign err_start = dp_active_q && hresp && !hready;
  assign can_issue = !hwrite_q || wr_valid;
  assign issue     = (st_q == ST_RUN) && adv && (remain_q != '0) && can_issue;

  bsplit_wbuf #(.DW(DW)) u_wbuf (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .take     (issue && hwrite_q),
    .wdata_in (wr_data),
    .hwdata   (hwdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      htrans_q    <= HT_IDLE;
      haddr_q     <= '0;
      nxt_addr_q  <= '0;
      hburst_q    <= HB_SINGLE;
      hwrite_q    <= 1'b0;
      remain_q    <= '0;
      pkt_left_q  <= '0;
      dp_active_q <= 1'b0;
      dp_write_q  <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      rd_valid_q  <= 1'b0;
      rd_data_q   <= '0;
    end else begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;

      // data phase bookkeeping on every accepted edge
      if (adv) begin
        if (dp_active_q && !dp_write_q && !hresp) begin
          rd_valid_q <= 1'b1;
          rd_data_q  <= hrdata;
        end
        dp_active_q <= htrans_q[1];
        dp_write_q  <= hwrite_q;
      end

      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_words == '0) begin
              done_q <= 1'b1;
            end else begin
              st_q       <= ST_RUN;
              nxt_addr_q <= req_addr;
              remain_q   <= req_words;
              pkt_left_q <= '0;
              hwrite_q   <= req_write;
            end
          end
        end

        ST_RUN: begin
          if (err_start) begin
            htrans_q <= HT_IDLE;
            st_q     <= ST_ABORT;
          end else if (adv) begin
            if (remain_q == '0) begin
              htrans_q <= HT_IDLE;
              if (!htrans_q[1]) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end
            end else if (pkt_left_q == '0) begin
              if (can_issue) begin
                htrans_q   <= HT_NONSEQ;
                hburst_q   <= sel_burst;
                haddr_q    <= nxt_addr_q;
                nxt_addr_q <= nxt_addr_q + STEP;
                remain_q   <= remain_q - ONE;
                pkt_left_q <= sel_m1;
              end else begin
                htrans_q <= HT_IDLE;
              end
            end else begin
              haddr_q <= nxt_addr_q;
              if (can_issue) begin
                htrans_q   <= HT_SEQ;
                nxt_addr_q <= nxt_addr_q + STEP;
                remain_q   <= remain_q - ONE;
                pkt_left_q <= pkt_left_q - 3'd1;
              end else begin
                htrans_q <= HT_BUSY;
              end
            end
          end
        end

        ST_ABORT: begin
          htrans_q <= HT_IDLE;
          if (adv) begin
            st_q       <= ST_IDLE;
            done_q     <= 1'b1;
            err_q      <= 1'b1;
            remain_q   <= '0;
            pkt_left_q <= '0;
          end
        end

        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign wr_ready  = issue && hwrite_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign done      = done_q;
  assign error     = err_q;
  assign haddr     = haddr_q;
  assign htrans    = htrans_q;
  assign hburst    = hburst_q;
  assign hsize     = HS_WORD;
  assign hwrite    = hwrite_q;
endmodule

// File: rtl/bsplit_chk.sv
module bsplit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic [2:0]    hburst,
  input logic          hready,
  input logic          hresp,
  input logic          done,
  input logic          error,
  input logic          req_ready
);
  AST_BURST_ENC: assert property (@(posedge clk) disable iff (rst)
    htrans == 2'b10 |-> (hburst == 3'b101 || hburst == 3'b011 || hburst == 3'b000)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (hready && htrans[1]) |=> (!htrans[0] || haddr == $past(haddr) + AW'(4))); // R3

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hready && !hresp && htrans != 2'b00)
      |=> ($stable(haddr) && $stable(htrans) && $stable(hburst))); // R4

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> htrans == 2'b00); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready); // R7

  AST_ERR_DONE: assert property (@(posedge clk) disable iff (rst)
    error |-> (done && htrans == 2'b00)); // R9
endmodule

bind burst_splitter bsplit_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .haddr     (haddr),
  .htrans    (htrans),
  .hburst    (hburst),
  .hready    (hready),
  .hresp     (hresp),
  .done      (done),
  .error     (error),
  .req_ready (req_ready)
);

// File: tb/burst_splitter_tb.sv
module burst_splitter_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_words;
  logic          wr_valid, wr_ready;
  logic [DW-1:0] wr_data;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          done, error;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic [2:0]    hburst, hsize;
  logic          hwrite;
  logic [DW-1:0] hwdata;
  logic          hready, hresp;
  logic [DW-1:0] hrdata;

  always #2 clk = ~clk;

  burst_splitter #(.AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // scoreboard queues
  logic [AW+2:0] pkt_q[$];   // {addr, hburst}
  logic [DW-1:0] rd_q[$];
  logic [DW-1:0] wq[$];
  logic [DW-1:0] mem [logic [AW-1:0]];

  bit stall_mode = 0;
  bit wr_gap = 0;
  int err_beat = -1;
  int beat_no = 0;
  int nonseq_cnt = 0;
  int busy_seen = 0;
  int seq_bad = 0;
  int hold_seen = 0;
  int hold_bad = 0;
  logic [AW-1:0] exp_seq_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hA5A5_0000;
  endfunction

  // bus slave and packet monitor
  initial begin
    logic          nv, nw, took, started;
    logic [AW-1:0] na;
    logic          sdp_v, sdp_w;
    logic [AW-1:0] sdp_a;
    logic [1:0]    p_htrans;
    logic [AW-1:0] p_haddr;
    logic          p_hold;
    int            err_st;
    hready = 1'b1; hresp = 1'b0; hrdata = '0;
    sdp_v = 0; sdp_w = 0; sdp_a = '0; err_st = 0; p_hold = 0;
    p_htrans = 2'b00; p_haddr = '0; na = '0; nw = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (p_hold) begin
          hold_seen++;
          if (htrans != p_htrans || haddr != p_haddr) hold_bad++;
        end
        if (htrans == 2'b01) busy_seen++;
      end
      p_hold = !rst && !hready && !hresp && htrans != 2'b00;
      p_htrans = htrans; p_haddr = haddr;
      nv = 0;
      if (hready && !rst) begin
        if (sdp_v && sdp_w && !hresp) mem[sdp_a] = hwdata;
        if (htrans[1]) begin nv = 1; na = haddr; nw = hwrite; end
        if (htrans == 2'b10) begin
          nonseq_cnt++;
          if (pkt_q.size() == 0) begin
            chk(0, "R2", "unexpected packet", {haddr[28:0], hburst}, 32'h0);
          end else begin
            logic [AW+2:0] e;
            e = pkt_q.pop_front();
            chk(e == {haddr, hburst}, "R2", "packet addr/burst",
                {haddr[28:0], hburst}, e[31:0]);
          end
          exp_seq_addr = haddr + 4;
        end else if (htrans == 2'b11) begin
          if (haddr != exp_seq_addr) seq_bad++;
          exp_seq_addr = haddr + 4;
        end
      end
      took = hready;
      @(posedge clk); #1;
      started = 0;
      if (took) begin
        sdp_v = nv; sdp_a = na; sdp_w = nw; started = nv;
      end
      if (err_st == 1) begin
        hready = 1; hresp = 1; err_st = 2;
      end else if (started && beat_no == err_beat) begin
        hready = 0; hresp = 1; err_st = 1;
      end else begin
        hresp = 0; err_st = 0;
        hready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      end
      if (started) beat_no++;
      hrdata = mem_rd(sdp_a);
    end
  end

  // write word source
  initial begin
    int gap_cnt;
    gap_cnt = 0;
    wr_valid = 0; wr_data = '0;
    forever begin
      @(negedge clk);
      if (wq.size() > 0 && gap_cnt == 0) begin
        wr_valid = 1; wr_data = wq[0];
      end else begin
        wr_valid = 0;
      end
      if (gap_cnt > 0) gap_cnt--;
      #1;
      if (wr_valid && wr_ready) begin
        void'(wq.pop_front());
        if (wr_gap) gap_cnt = 3;
      end
    end
  end

  // read data monitor (R6)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rd_valid) begin
        if (rd_q.size() == 0) begin
          chk(0, "R6", "unexpected read word", rd_data, 32'h0);
        end else begin
          logic [DW-1:0] e;
          e = rd_q.pop_front();
          chk(rd_data == e, "R6", "read word", rd_data, e);
        end
      end
    end
  end

  task automatic run_req(input logic [AW-1:0] addr, input int words, input bit wr,
                         input bit stall, input bit gap, input int ebeat);
    int remain, b, n, cyc;
    logic [AW-1:0] a;
    logic [2:0] code;
    bit seen, got_err;
    stall_mode = stall; wr_gap = gap; err_beat = ebeat; beat_no = 0;
    remain = words; a = addr; b = 0;
    while (remain > 0) begin
      n = (remain >= 8) ? 8 : (remain >= 4) ? 4 : 1;
      code = (n == 8) ? 3'b101 : (n == 4) ? 3'b011 : 3'b000;
      if (ebeat < 0 || b <= ebeat) pkt_q.push_back({a, code});
      a += AW'(4 * n); remain -= n; b += n;
    end
    for (int i = 0; i < words; i++) begin
      if (wr) wq.push_back(32'hC0DE_0000 + i);
      else if (ebeat < 0 || i < ebeat) rd_q.push_back(mem_rd(addr + AW'(4 * i)));
    end
    @(negedge clk);
    req_valid = 1; req_addr = addr; req_words = CW'(words); req_write = wr;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R7", "req_ready low while busy", {31'd0, req_ready}, 32'h0);
    seen = 0; got_err = 0; cyc = 0;
    while (!seen && cyc < 3000) begin
      if (done) begin seen = 1; got_err = error; end
      else begin @(negedge clk); cyc++; end
    end
    chk(seen, "R7", "done observed", {31'd0, seen}, 32'h1);
    chk(got_err == (ebeat >= 0), "R9", "error flag with done", {31'd0, got_err},
        {31'd0, ebeat >= 0});
    @(negedge clk);
    chk(done == 0, "R7", "done is a single pulse", {31'd0, done}, 32'h0);
    chk(pkt_q.size() == 0, "R2", "all expected packets seen", pkt_q.size(), 32'h0);
    chk(rd_q.size() == 0, "R6", "all read words returned", rd_q.size(), 32'h0);
    if (wr) begin
      for (int i = 0; i < words; i++)
        chk(mem_rd(addr + AW'(4 * i)) == 32'hC0DE_0000 + i, "R5", "written word",
            mem_rd(addr + AW'(4 * i)), 32'hC0DE_0000 + i);
    end
    wq.delete(); pkt_q.delete(); rd_q.delete();
    stall_mode = 0; wr_gap = 0; err_beat = -1;
  endtask

  // watchdog
  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    rst = 1; req_valid = 0; req_addr = '0; req_words = '0; req_write = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(htrans == 2'b00, "R1", "htrans in reset", {30'd0, htrans}, 32'h0);
    chk(done == 0 && error == 0 && rd_valid == 0, "R1", "status low in reset",
        {29'd0, done, error, rd_valid}, 32'h0);
    chk(req_ready == 1, "R1", "req_ready in reset", {31'd0, req_ready}, 32'h1);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(htrans == 2'b00 && req_ready == 1, "R1", "idle after reset",
        {29'd0, htrans, req_ready}, 32'h1);
    chk(hsize == 3'b010, "R2", "hsize word", {29'd0, hsize}, 32'h2);

    // R2 R3 R6: read 13 words -> 8,4,1
    run_req(32'h0000_0100, 13, 0, 0, 0, -1);
    // R4 R6: read 20 with stalls -> 8,8,4
    run_req(32'h0000_1000, 20, 0, 1, 0, -1);
    chk(hold_seen > 0 && hold_bad == 0, "R4", "address phase held while waited",
        hold_bad, 32'h0);
    // R5: write 7 with gaps -> 4,1,1,1
    busy_seen = 0;
    run_req(32'h0000_2000, 7, 1, 0, 1, -1);
    chk(busy_seen > 0, "R5", "BUSY inserted for missing write word", busy_seen, 32'h1);
    // R5 R4: write 12 with stalls -> 8,4
    run_req(32'h0000_2100, 12, 1, 1, 0, -1);
    // R2: largest count 63 -> 7x8,4,1,1,1
    run_req(32'h0000_3000, 63, 0, 1, 0, -1);
    chk(seq_bad == 0, "R3", "SEQ addresses step by 4", seq_bad, 32'h0);

    // R8: zero words
    n0 = nonseq_cnt;
    @(negedge clk);
    req_valid = 1; req_addr = 32'h40; req_words = '0; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    chk(done == 1 && error == 0, "R8", "zero count done next cycle",
        {30'd0, done, error}, 32'h2);
    repeat (3) @(negedge clk);
    chk(nonseq_cnt == n0 && htrans == 2'b00, "R8", "no bus activity for zero count",
        nonseq_cnt - n0, 32'h0);

    // R9: error on beat 5 of a 16-word read
    n0 = nonseq_cnt;
    run_req(32'h0000_4000, 16, 0, 0, 0, 5);
    chk(nonseq_cnt - n0 == 1, "R9", "no packet after abort", nonseq_cnt - n0, 32'h1);
    // recovery after abort
    run_req(32'h0000_5000, 5, 0, 0, 0, -1);
    chk(seq_bad == 0, "R3", "SEQ addresses step by 4 at end", seq_bad, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule